// File: doc/BRIEF.md
# Iterative Logical Shift-Right Unit

This block is a 32-bit logical right shifter that moves its operand one bit position per clock rather than through a single-cycle barrel network. A 5-bit down-counter holds the number of positions still to go; the same counter serves as the loop index of the repeated shift step. One control step repeats until the counter reaches zero, and the block then presents the result and raises a one-cycle completion pulse.

The shift amount comes from a 5-bit constant field of the instruction. When that constant is zero, the count is taken instead from the low five bits of a 32-bit count register value supplied on a separate input. The operand is first copied unchanged into the result register. Each shift step then moves the result right by one, feeds a zero into the top bit and decrements the counter. A start request is accepted only while the unit is idle. Every input is sampled in the cycle the start is accepted.

Top module: `iter_srl_unit`

## Requirements
- R1: After a synchronous reset, `result_o` is 0, `done_o` is 0 and `cnt_zero_o` is 1.
- R2: A start accepted while idle copies `operand_i` unchanged into `result_o`, visible in the cycle after the accepting edge.
- R3: The shift count is `imm_cnt_i` when it is nonzero. When `imm_cnt_i` is zero, the count is bits 4..0 of `reg_cnt_i` as sampled at the start; the upper 27 bits of `reg_cnt_i` are ignored.
- R4: Each shift step moves the result right by one position, places 0 in bit 31 and decrements the counter by one. No step occurs while the counter holds zero.
- R5: `done_o` is high for exactly one cycle. It rises n+3 cycles after the accepting edge, where n is the shift count (the first cycle after that edge counts as 1).
- R6: While `done_o` is high, `result_o` equals `operand_i` logically shifted right by n. The value holds until the next accepted start.
- R7: When both count sources are zero, the result is the operand unchanged and `done_o` rises 3 cycles after the accepting edge.
- R8: `cnt_zero_o` is 1 exactly when the counter holds zero. It is therefore 1 whenever `done_o` is high.
- R9: A start request that arrives while a shift is in progress has no effect on the running shift, its result or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a shift; taken only when idle |
| imm_cnt_i | input | 5 | Constant shift count from the instruction |
| reg_cnt_i | input | 32 | Count register value; low 5 bits used when the constant is zero |
| operand_i | input | 32 | Value to be shifted |
| result_o | output | 32 | Result register |
| done_o | output | 1 | One-cycle pulse when the result is final |
| cnt_zero_o | output | 1 | Counter-equals-zero flag |

## Verification
A counter that loads the wrong source or decrements once too often or too rarely shows up at `done_o`. The pulse arrives early or late against the n+3 schedule, and `result_o` holds a value shifted by the wrong amount. A datapath fault appears at `result_o` as a nonzero top bit or a wrong value on the first cycle a step runs. The bench compares every output against a behavioural model on every clock, so any such divergence is reported in the same cycle it reaches a port. A start that wrongly restarts a busy unit shows up as a replaced result and a moved completion pulse.

// File: rtl/srl_pkg.sv
package srl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CHECK = 2'd1,
    PH_STEP  = 2'd2
  } srl_phase_e;
endpackage

// File: rtl/srl_count_reg.sv
module srl_count_reg #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_imm,
  input  logic [CNT_W-1:0] imm_cnt,
  input  logic [CNT_W-1:0] alt_cnt,
  input  logic             ld_alt,
  input  logic             dec_en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, alt_q, cnt_nxt;
  logic             zero_q;

  always_comb begin
    cnt_nxt = cnt_q;
    if (ld_imm)      cnt_nxt = imm_cnt;
    else if (ld_alt) cnt_nxt = alt_q;
    else if (dec_en) cnt_nxt = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      alt_q  <= '0;
      zero_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_nxt;
      zero_q <= (cnt_nxt == '0);
      if (ld_imm) alt_q <= alt_cnt;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = zero_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    dec_en |-> !zero_q); // R4
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (dec_en && !ld_imm && !ld_alt) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R4
endmodule

// File: rtl/srl_shift_datapath.sv
module srl_shift_datapath #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [DATA_W-1:0] operand,
  input  logic              shift_en,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] res_q, res_nxt;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic upper;
    if (b == DATA_W - 1) begin : g_top
      assign upper = 1'b0;
    end else begin : g_mid
      assign upper = res_q[b+1];
    end
    assign res_nxt[b] = load_en  ? operand[b] :
                        shift_en ? upper      : res_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= res_nxt;
  end

  assign result_o = res_q;

  AST_TOP_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load_en) |=> !res_q[DATA_W-1]); // R4
  AST_COPY_OPERAND: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (res_q == $past(operand))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !shift_en) |=> $stable(res_q)); // R6
endmodule

// File: rtl/srl_sequencer.sv
module srl_sequencer
  import srl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic cnt_zero_i,
  output logic ld_imm_o,
  output logic ld_alt_o,
  output logic load_op_o,
  output logic shift_o,
  output logic done_o
);
  srl_phase_e ph_q, ph_nxt;
  logic       done_q;

  always_comb begin
    ph_nxt    = ph_q;
    ld_imm_o  = 1'b0;
    ld_alt_o  = 1'b0;
    load_op_o = 1'b0;
    shift_o   = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        ld_imm_o  = 1'b1;
        load_op_o = 1'b1;
        ph_nxt    = PH_CHECK;
      end
      PH_CHECK: begin
        ld_alt_o = cnt_zero_i;
        ph_nxt   = PH_STEP;
      end
      PH_STEP: begin
        if (cnt_zero_i) ph_nxt = PH_IDLE;
        else            shift_o = 1'b1;
      end
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_nxt;
      done_q <= (ph_q == PH_STEP) && cnt_zero_i;
    end
  end

  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R5
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE && start_i) |-> !ld_imm_o); // R9
  AST_CHECK_THEN_STEP: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_CHECK) |=> (ph_q == PH_STEP)); // R3
endmodule

// File: rtl/iter_srl_unit.sv
module iter_srl_unit #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  imm_cnt_i,
  input  logic [DATA_W-1:0] reg_cnt_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o,
  output logic              cnt_zero_o
);
  logic ld_imm, ld_alt, load_op, shift_en, cnt_zero;
  logic [CNT_W-1:0] cnt_val;

  srl_sequencer u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .cnt_zero_i(cnt_zero),
    .ld_imm_o(ld_imm), .ld_alt_o(ld_alt), .load_op_o(load_op),
    .shift_o(shift_en), .done_o(done_o)
  );

  srl_count_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ld_imm(ld_imm), .imm_cnt(imm_cnt_i),
    .alt_cnt(reg_cnt_i[CNT_W-1:0]), .ld_alt(ld_alt), .dec_en(shift_en),
    .cnt_o(cnt_val), .zero_o(cnt_zero)
  );

  srl_shift_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .load_en(load_op), .operand(operand_i),
    .shift_en(shift_en), .result_o(result_o)
  );

  assign cnt_zero_o = cnt_zero;

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    done_o |-> cnt_zero_o); // R8
  AST_ZERO_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    cnt_zero_o == (cnt_val == '0)); // R8
endmodule

// File: tb/iter_srl_unit_tb_top.sv
module iter_srl_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [4:0]  imm_cnt_i = '0;
  logic [31:0] reg_cnt_i = '0;
  logic [31:0] operand_i = '0;
  logic [31:0] result_o;
  logic        done_o, cnt_zero_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  iter_srl_unit dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .imm_cnt_i(imm_cnt_i),
    .reg_cnt_i(reg_cnt_i), .operand_i(operand_i), .result_o(result_o),
    .done_o(done_o), .cnt_zero_o(cnt_zero_o)
  );

  // Behavioural reference: how many shifts are left and what the answer is.
  int          m_busy_cycles;  // 0 = idle, else cycles since acceptance
  int          m_left;
  int          m_pending_alt;
  logic [31:0] m_val;
  logic        m_done;

  always @(posedge clk) begin
    if (rst) begin
      m_busy_cycles = 0; m_left = 0; m_val = '0; m_done = 1'b0; m_pending_alt = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy_cycles == 0) begin
        if (start_i) begin
          m_val = operand_i;
          m_left = int'(imm_cnt_i);
          m_pending_alt = int'(reg_cnt_i % 32);
          m_busy_cycles = 1;
        end
      end else if (m_busy_cycles == 1) begin
        if (m_left == 0) m_left = m_pending_alt;
        m_busy_cycles = 2;
      end else if (m_left > 0) begin
        m_val = m_val / 2;
        m_left = m_left - 1;
        m_busy_cycles++;
      end else begin
        m_busy_cycles = 0;
        m_done = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst) begin
      chk(result_o == m_val, "R6/R4 result", result_o, m_val);
      chk(done_o == m_done, "R5 done", 32'(done_o), 32'(m_done));
      chk(cnt_zero_o == (m_left == 0), "R8 zero flag", 32'(cnt_zero_o),
          32'(m_left == 0));
    end
  end

  task automatic run_shift(input logic [4:0] imm, input logic [31:0] rc,
                           input logic [31:0] op, input int n, input bit poke,
                           input string tag);
    int k;
    logic [31:0] exp;
    exp = op >> n;
    @(posedge clk); #2;
    start_i = 1'b1; imm_cnt_i = imm; reg_cnt_i = rc; operand_i = op;
    @(posedge clk); #2;
    start_i = 1'b0; operand_i = ~op; imm_cnt_i = 5'd1; reg_cnt_i = 32'd9;
    @(negedge clk);
    chk(result_o == op, "R2 operand copied", result_o, op);
    k = 1;
    while (!done_o && k < 60) begin
      @(negedge clk);
      k++;
      if (poke && k == 2) begin start_i = 1'b1; operand_i = 32'hDEADBEEF; end
      if (poke && k == 3) start_i = 1'b0;
    end
    start_i = 1'b0;
    chk(k == n + 3, {tag, " R5 latency"}, 32'(k), 32'(n + 3));
    chk(result_o == exp, {tag, " R6 final result"}, result_o, exp);
    chk(cnt_zero_o == 1'b1, {tag, " R8 zero at done"}, 32'(cnt_zero_o), 32'd1);
    @(negedge clk);
    chk(done_o == 1'b0, {tag, " R5 one-cycle pulse"}, 32'(done_o), 32'd0);
    chk(result_o == exp, {tag, " R6 result held"}, result_o, exp);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(result_o == 32'd0, "R1 reset result", result_o, 32'd0);
    chk(done_o == 1'b0, "R1 reset done", 32'(done_o), 32'd0);
    chk(cnt_zero_o == 1'b1, "R1 reset zero flag", 32'(cnt_zero_o), 32'd1);

    run_shift(5'd5,  32'd12,        32'h8000_0001, 5,  1'b0, "R4 const5");
    run_shift(5'd1,  32'd0,         32'hFFFF_FFFF, 1,  1'b0, "R4 const1");
    run_shift(5'd31, 32'd0,         32'hF000_0000, 31, 1'b0, "R4 const31");
    run_shift(5'd0,  32'd7,         32'h1234_5678, 7,  1'b0, "R3 regcount7");
    run_shift(5'd0,  32'hFFFF_FFE3, 32'hA5A5_A5A5, 3,  1'b0, "R3 upper bits ignored");
    run_shift(5'd0,  32'd31,        32'hFFFF_FFFF, 31, 1'b0, "R3 regcount31");
    run_shift(5'd0,  32'hFFFF_FFE0, 32'hCAFE_F00D, 0,  1'b0, "R7 both zero");
    run_shift(5'd4,  32'd0,         32'h0F0F_0F0F, 4,  1'b1, "R9 busy start");
    run_shift(5'd0,  32'd0,         32'h8000_0000, 0,  1'b1, "R9 busy start zero");

    // Idle with no start: nothing moves.
    repeat (4) @(negedge clk);
    chk(result_o == 32'h8000_0000, "R6 idle hold", result_o, 32'h8000_0000);
    chk(done_o == 1'b0, "R5 no spurious done", 32'(done_o), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule